// File: doc/BRIEF.md
# Byte-Wide Accumulator Processor Core

This block is a small multi-cycle processor that executes a fixed subset of a classic 8-bit accumulator instruction set. It holds an accumulator, two index registers, an 8-bit stack pointer, a 16-bit program counter and four condition flags (negative, overflow, zero, carry). All traffic goes over a single byte-wide synchronous memory port. The memory returns read data one clock after it sees an address, and it stores write data on the clock edge at which the write strobe is high.

Once reset is released, the core reads its start address from the reset vector. It then fetches, decodes and executes one instruction after another. The supported opcodes are:

- loads and stores;
- increments and decrements;
- a left rotate through carry;
- a register compare and a subtract-with-borrow;
- three conditional relative branches;
- an absolute jump;
- subroutine call and return through the stack page;
- a stack-pointer load and a no-op.

Any other opcode byte stops the core. It raises a halt flag and shows the address of the offending opcode on a port. The register file and the flags are brought out on observation ports.

Top module: `acc8_core`

## Requirements
- R1: While reset is high and immediately after it, A, X, Y, SP and all flags are zero, `halted` is low, no write is issued, and the first two bus reads go to 0xFFFC and then 0xFFFD. The start address is taken little-endian from those two bytes.
- R2: Read data on `mem_rdata` is consumed one cycle after its address is presented. A write stores `mem_wdata` at `mem_addr` in a cycle with `mem_we` high.
- R3: Operand bytes follow the opcode, and 16-bit operands are little-endian. PC steps past each operand byte. 0x4C jumps to the absolute operand, and 0x8E stores X to the absolute operand address.
- R4: 0xA9 loads A with the immediate byte, 0xA5 loads A from a zero-page address and 0xA4 loads Y from a zero-page address. Each sets N from bit 7 and Z when the value is zero.
- R5: 0x86 writes X to zero-page memory, and 0x8E writes X to an absolute address. Neither changes flags.
- R6: 0xCA decrements X, 0x88 decrements Y and 0xC8 increments Y, each modulo 256. 0xE6 reads a zero-page byte, adds one and writes it back. All four update N and Z from the new value.
- R7: 0x2A rotates A left. The old bit 7 goes to C, the old C enters bit 0, and N and Z follow the result.
- R8: 0xE0 compares X with an immediate. It sets C when X ≥ operand (unsigned), sets N and Z from the 8-bit difference, and leaves X and V unchanged.
- R9: 0xE9 sets A to A − operand − (1 − C), taking the low 8 bits. C is 1 exactly when no borrow occurred. V is 1 when the operands' signs differ and the result's sign differs from the old A. N and Z follow the result.
- R10: 0xD0 branches when Z=0, 0x90 branches when C=0 and 0xB0 branches when C=1. A taken branch adds the sign-extended offset to the address that follows the offset byte.
- R11: 0x20 pushes the address of its own last operand byte, high byte first, to 0x0100+SP with post-decrement, then jumps. 0x60 pulls low then high with pre-increment and resumes at that address plus one. 0x9A copies X to SP with no flag change, and 0xEA does nothing.
- R12: Any other opcode sets `halted`, which stays set until reset. `halt_addr` holds the opcode's address, and no further writes or state changes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| halted | output | 1 | Undefined opcode seen; core stopped |
| halt_addr | output | 16 | Address of the undefined opcode |
| dbg_a | output | 8 | Accumulator |
| dbg_x | output | 8 | X index register |
| dbg_y | output | 8 | Y index register |
| dbg_sp | output | 8 | Stack pointer |
| dbg_flags | output | 4 | Flags: bit 3 N, bit 2 V, bit 1 Z, bit 0 C |

## Verification
Subtract-with-borrow is run with a borrow-in, with a signed overflow from the largest negative value, and with a result of exactly 0xFF. A core that inverts the carry sense or tests overflow on the wrong pair of signs finishes with the wrong A or the wrong flag nibble. The compare feeds its carry into two rotates, so a wrong unsigned test shows up as a different accumulator value. The call/return test checks both pushed bytes and their order. It also returns to a store that must run, and it ends in a backward branch loop with a negative offset. An off-by-one return address, a swapped push order or an unsigned offset would all change the write stream or the final halt address. A taken carry-clear branch that skips an undefined byte shows whether the branch condition and the halt detection are correct.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [3:0] {
        S_VEC_LO, S_VEC_HI, S_VEC_LD, S_FETCH, S_DECODE,
        S_OPND1, S_OPND2, S_ZREAD, S_PUSH_LO, S_PULL_LO,
        S_PULL_HI, S_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_INC, ALU_DEC, ALU_ROL, ALU_CMP, ALU_SBC
    } alu_op_e;

    typedef enum logic [2:0] {
        M_IMPL, M_IMM, M_ZP, M_ABS, M_REL, M_PULL, M_BAD
    } mode_e;

    typedef enum logic [1:0] { SRC_A, SRC_X, SRC_Y, SRC_MEM } src_e;

    typedef enum logic [2:0] {
        DST_NONE, DST_A, DST_X, DST_Y, DST_SP, DST_MEM
    } dst_e;

    typedef enum logic [2:0] {
        F_NONE, F_JMP, F_JSR, F_RTS, F_BNE, F_BCC, F_BCS
    } flow_e;

    typedef struct packed {
        mode_e   mode;
        alu_op_e alu;
        src_e    src;
        dst_e    dst;
        flow_e   flow;
        logic    store;
        logic    upd;
    } decode_t;

    localparam byte_t OP_LDA_IMM = 8'hA9;
    localparam byte_t OP_LDA_ZP  = 8'hA5;
    localparam byte_t OP_LDY_ZP  = 8'hA4;
    localparam byte_t OP_STX_ZP  = 8'h86;
    localparam byte_t OP_STX_ABS = 8'h8E;
    localparam byte_t OP_DEX     = 8'hCA;
    localparam byte_t OP_DEY     = 8'h88;
    localparam byte_t OP_INY     = 8'hC8;
    localparam byte_t OP_INC_ZP  = 8'hE6;
    localparam byte_t OP_ROL_A   = 8'h2A;
    localparam byte_t OP_CPX_IMM = 8'hE0;
    localparam byte_t OP_SBC_IMM = 8'hE9;
    localparam byte_t OP_BNE     = 8'hD0;
    localparam byte_t OP_BCC     = 8'h90;
    localparam byte_t OP_BCS     = 8'hB0;
    localparam byte_t OP_JMP     = 8'h4C;
    localparam byte_t OP_JSR     = 8'h20;
    localparam byte_t OP_RTS     = 8'h60;
    localparam byte_t OP_TXS     = 8'h9A;
    localparam byte_t OP_NOP     = 8'hEA;

    function automatic decode_t mk_dec(mode_e m, alu_op_e a, src_e s, dst_e d,
                                       flow_e f, logic st, logic u);
        decode_t r;
        r.mode = m; r.alu = a; r.src = s; r.dst = d;
        r.flow = f; r.store = st; r.upd = u;
        return r;
    endfunction

    function automatic addr_t sext_add(addr_t base, byte_t off);
        return base + {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
    endfunction

endpackage

// File: rtl/acc8_decode.sv
`timescale 1ns/1ps
module acc8_decode
    import acc8_pkg::*;
(
    input  byte_t   opcode,
    output decode_t dec
);
    always_comb begin
        case (opcode)
            OP_LDA_IMM: dec = mk_dec(M_IMM,  ALU_PASS, SRC_MEM, DST_A,    F_NONE, 1'b0, 1'b1);
            OP_LDA_ZP:  dec = mk_dec(M_ZP,   ALU_PASS, SRC_MEM, DST_A,    F_NONE, 1'b0, 1'b1);
            OP_LDY_ZP:  dec = mk_dec(M_ZP,   ALU_PASS, SRC_MEM, DST_Y,    F_NONE, 1'b0, 1'b1);
            OP_STX_ZP:  dec = mk_dec(M_ZP,   ALU_PASS, SRC_X,   DST_NONE, F_NONE, 1'b1, 1'b0);
            OP_STX_ABS: dec = mk_dec(M_ABS,  ALU_PASS, SRC_X,   DST_NONE, F_NONE, 1'b1, 1'b0);
            OP_DEX:     dec = mk_dec(M_IMPL, ALU_DEC,  SRC_X,   DST_X,    F_NONE, 1'b0, 1'b1);
            OP_DEY:     dec = mk_dec(M_IMPL, ALU_DEC,  SRC_Y,   DST_Y,    F_NONE, 1'b0, 1'b1);
            OP_INY:     dec = mk_dec(M_IMPL, ALU_INC,  SRC_Y,   DST_Y,    F_NONE, 1'b0, 1'b1);
            OP_INC_ZP:  dec = mk_dec(M_ZP,   ALU_INC,  SRC_MEM, DST_MEM,  F_NONE, 1'b0, 1'b1);
            OP_ROL_A:   dec = mk_dec(M_IMPL, ALU_ROL,  SRC_A,   DST_A,    F_NONE, 1'b0, 1'b1);
            OP_CPX_IMM: dec = mk_dec(M_IMM,  ALU_CMP,  SRC_X,   DST_NONE, F_NONE, 1'b0, 1'b1);
            OP_SBC_IMM: dec = mk_dec(M_IMM,  ALU_SBC,  SRC_A,   DST_A,    F_NONE, 1'b0, 1'b1);
            OP_BNE:     dec = mk_dec(M_REL,  ALU_PASS, SRC_A,   DST_NONE, F_BNE,  1'b0, 1'b0);
            OP_BCC:     dec = mk_dec(M_REL,  ALU_PASS, SRC_A,   DST_NONE, F_BCC,  1'b0, 1'b0);
            OP_BCS:     dec = mk_dec(M_REL,  ALU_PASS, SRC_A,   DST_NONE, F_BCS,  1'b0, 1'b0);
            OP_JMP:     dec = mk_dec(M_ABS,  ALU_PASS, SRC_A,   DST_NONE, F_JMP,  1'b0, 1'b0);
            OP_JSR:     dec = mk_dec(M_ABS,  ALU_PASS, SRC_A,   DST_NONE, F_JSR,  1'b0, 1'b0);
            OP_RTS:     dec = mk_dec(M_PULL, ALU_PASS, SRC_A,   DST_NONE, F_RTS,  1'b0, 1'b0);
            OP_TXS:     dec = mk_dec(M_IMPL, ALU_PASS, SRC_X,   DST_SP,   F_NONE, 1'b0, 1'b0);
            OP_NOP:     dec = mk_dec(M_IMPL, ALU_PASS, SRC_A,   DST_NONE, F_NONE, 1'b0, 1'b0);
            default:    dec = mk_dec(M_BAD,  ALU_PASS, SRC_A,   DST_NONE, F_NONE, 1'b0, 1'b0);
        endcase
    end
endmodule

// File: rtl/acc8_alu.sv
`timescale 1ns/1ps
module acc8_alu
    import acc8_pkg::*;
(
    input  alu_op_e op,
    input  byte_t   a,
    input  byte_t   b,
    input  flags_t  fin,
    output byte_t   res,
    output flags_t  fout
);
    logic [DATA_W:0] diff;

    always_comb begin
        fout = fin;
        diff = '0;
        res  = a;
        case (op)
            ALU_PASS: res = a;
            ALU_INC:  res = a + 8'd1;
            ALU_DEC:  res = a - 8'd1;
            ALU_ROL: begin
                res    = {a[DATA_W-2:0], fin.c};
                fout.c = a[DATA_W-1];
            end
            ALU_CMP: begin
                res    = a - b;
                fout.c = (a >= b);
            end
            ALU_SBC: begin
                diff   = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, ~fin.c};
                res    = diff[DATA_W-1:0];
                fout.c = ~diff[DATA_W];
                fout.v = (a[DATA_W-1] ^ b[DATA_W-1]) & (a[DATA_W-1] ^ diff[DATA_W-1]);
            end
            default: res = a;
        endcase
        fout.n = res[DATA_W-1];
        fout.z = (res == '0);
    end
endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
module acc8_core
    import acc8_pkg::*;
#(
    parameter logic [15:0] RESET_VECTOR = 16'hFFFC,
    parameter logic [7:0]  STACK_PAGE   = 8'h01
)(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic        halted,
    output logic [15:0] halt_addr,
    output logic [7:0]  dbg_a,
    output logic [7:0]  dbg_x,
    output logic [7:0]  dbg_y,
    output logic [7:0]  dbg_sp,
    output logic [3:0]  dbg_flags
);
    localparam addr_t VEC_HI_ADDR = RESET_VECTOR + 16'd1;

    state_e state_q, state_d;
    addr_t  pc_q, pc_d, halt_q, halt_d;
    byte_t  a_q, a_d, x_q, x_d, y_q, y_d, sp_q, sp_d;
    byte_t  ir_q, ir_d, lo_q, lo_d, hi_q, hi_d;
    flags_t fl_q, fl_d;

    byte_t   op_sel;
    decode_t dec;
    byte_t   alu_a, alu_res;
    flags_t  alu_fl;
    addr_t   pc_m1;
    logic    exec_now;
    logic    take;

    function automatic addr_t stk(byte_t p);
        return {STACK_PAGE, p};
    endfunction

    assign op_sel = (state_q == S_DECODE) ? mem_rdata : ir_q;
    assign pc_m1  = pc_q - 16'd1;

    acc8_decode u_dec (.opcode(op_sel), .dec(dec));

    always_comb begin
        case (dec.src)
            SRC_A:   alu_a = a_q;
            SRC_X:   alu_a = x_q;
            SRC_Y:   alu_a = y_q;
            default: alu_a = mem_rdata;
        endcase
    end

    acc8_alu u_alu (
        .op(dec.alu), .a(alu_a), .b(mem_rdata), .fin(fl_q),
        .res(alu_res), .fout(alu_fl)
    );

    always_comb begin
        case (dec.flow)
            F_BNE:   take = ~fl_q.z;
            F_BCC:   take = ~fl_q.c;
            F_BCS:   take = fl_q.c;
            default: take = 1'b0;
        endcase
    end

    assign exec_now = ((state_q == S_DECODE) && (dec.mode == M_IMPL)) ||
                      ((state_q == S_OPND1)  && (dec.mode == M_IMM))  ||
                      (state_q == S_ZREAD);

    always_comb begin
        state_d = state_q; pc_d = pc_q; halt_d = halt_q;
        a_d = a_q; x_d = x_q; y_d = y_q; sp_d = sp_q;
        ir_d = ir_q; lo_d = lo_q; hi_d = hi_q; fl_d = fl_q;
        mem_addr = pc_q; mem_we = 1'b0; mem_wdata = x_q;

        case (state_q)
            S_VEC_LO: begin
                mem_addr = RESET_VECTOR;
                state_d  = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_addr = VEC_HI_ADDR;
                lo_d     = mem_rdata;
                state_d  = S_VEC_LD;
            end
            S_VEC_LD: begin
                pc_d    = {mem_rdata, lo_q};
                state_d = S_FETCH;
            end
            S_FETCH: begin
                mem_addr = pc_q;
                pc_d     = pc_q + 16'd1;
                state_d  = S_DECODE;
            end
            S_DECODE: begin
                ir_d = mem_rdata;
                case (dec.mode)
                    M_BAD: begin
                        halt_d  = pc_m1;
                        state_d = S_HALT;
                    end
                    M_IMPL: state_d = S_FETCH;
                    M_PULL: begin
                        sp_d     = sp_q + 8'd1;
                        mem_addr = stk(sp_q + 8'd1);
                        state_d  = S_PULL_LO;
                    end
                    default: begin
                        mem_addr = pc_q;
                        pc_d     = pc_q + 16'd1;
                        state_d  = S_OPND1;
                    end
                endcase
            end
            S_OPND1: begin
                lo_d = mem_rdata;
                case (dec.mode)
                    M_REL: begin
                        if (take) pc_d = sext_add(pc_q, mem_rdata);
                        state_d = S_FETCH;
                    end
                    M_ZP: begin
                        mem_addr = {8'h00, mem_rdata};
                        if (dec.store) begin
                            mem_we  = 1'b1;
                            state_d = S_FETCH;
                        end else begin
                            state_d = S_ZREAD;
                        end
                    end
                    M_ABS: begin
                        mem_addr = pc_q;
                        pc_d     = pc_q + 16'd1;
                        state_d  = S_OPND2;
                    end
                    default: state_d = S_FETCH;
                endcase
            end
            S_OPND2: begin
                state_d = S_FETCH;
                if (dec.flow == F_JMP) begin
                    pc_d = {mem_rdata, lo_q};
                end else if (dec.flow == F_JSR) begin
                    hi_d      = mem_rdata;
                    mem_addr  = stk(sp_q);
                    mem_we    = 1'b1;
                    mem_wdata = pc_m1[15:8];
                    sp_d      = sp_q - 8'd1;
                    state_d   = S_PUSH_LO;
                end else begin
                    mem_addr = {mem_rdata, lo_q};
                    mem_we   = 1'b1;
                end
            end
            S_PUSH_LO: begin
                mem_addr  = stk(sp_q);
                mem_we    = 1'b1;
                mem_wdata = pc_m1[7:0];
                sp_d      = sp_q - 8'd1;
                pc_d      = {hi_q, lo_q};
                state_d   = S_FETCH;
            end
            S_ZREAD: begin
                if (dec.dst == DST_MEM) begin
                    mem_addr  = {8'h00, lo_q};
                    mem_we    = 1'b1;
                    mem_wdata = alu_res;
                end
                state_d = S_FETCH;
            end
            S_PULL_LO: begin
                lo_d     = mem_rdata;
                sp_d     = sp_q + 8'd1;
                mem_addr = stk(sp_q + 8'd1);
                state_d  = S_PULL_HI;
            end
            S_PULL_HI: begin
                pc_d    = {mem_rdata, lo_q} + 16'd1;
                state_d = S_FETCH;
            end
            default: state_d = S_HALT;
        endcase

        if (exec_now) begin
            case (dec.dst)
                DST_A:   a_d  = alu_res;
                DST_X:   x_d  = alu_res;
                DST_Y:   y_d  = alu_res;
                DST_SP:  sp_d = alu_res;
                default: ;
            endcase
            if (dec.upd) fl_d = alu_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_VEC_LO;
            pc_q <= '0; halt_q <= '0;
            a_q <= '0; x_q <= '0; y_q <= '0; sp_q <= '0;
            ir_q <= '0; lo_q <= '0; hi_q <= '0; fl_q <= '0;
        end else begin
            state_q <= state_d;
            pc_q <= pc_d; halt_q <= halt_d;
            a_q <= a_d; x_q <= x_d; y_q <= y_d; sp_q <= sp_d;
            ir_q <= ir_d; lo_q <= lo_d; hi_q <= hi_d; fl_q <= fl_d;
        end
    end

    assign halted    = (state_q == S_HALT);
    assign halt_addr = halt_q;
    assign dbg_a     = a_q;
    assign dbg_x     = x_q;
    assign dbg_y     = y_q;
    assign dbg_sp    = sp_q;
    assign dbg_flags = fl_q;
endmodule

// File: rtl/acc8_chk.sv
`timescale 1ns/1ps
module acc8_chk #(
    parameter logic [15:0] RESET_VECTOR = 16'hFFFC
)(
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        halted,
    input logic [15:0] halt_addr,
    input logic [3:0]  dbg_flags
);
    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R12
    halt_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(halt_addr) && $stable(dbg_flags)));

    // R1
    vec_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == RESET_VECTOR && !mem_we));

    // R1
    vec_hi_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) && !$past(rst)) |-> (mem_addr == RESET_VECTOR + 16'd1));
endmodule

bind acc8_core acc8_chk #(.RESET_VECTOR(RESET_VECTOR)) u_chk (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .halted(halted), .halt_addr(halt_addr), .dbg_flags(dbg_flags)
);

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic        halted;
    logic [15:0] halt_addr;
    logic [7:0]  dbg_a, dbg_x, dbg_y, dbg_sp;
    logic [3:0]  dbg_flags;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] mem [0:4095];

    typedef struct { logic [15:0] a; logic [7:0] d; string tag; } wr_t;
    wr_t exp_q[$];

    always #2.5 clk = ~clk;

    acc8_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
        .halt_addr(halt_addr), .dbg_a(dbg_a), .dbg_x(dbg_x), .dbg_y(dbg_y),
        .dbg_sp(dbg_sp), .dbg_flags(dbg_flags)
    );

    function automatic int idx(logic [15:0] a);
        return int'({a[15], a[10:0]});
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
        mem_rdata <= mem[idx(mem_addr)];
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(logic [15:0] a, logic [7:0] d, string tag);
        wr_t w;
        w.a = a; w.d = d; w.tag = tag;
        exp_q.push_back(w);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R5 unexpected write: actual=%h:%h expected=none", mem_addr, mem_wdata);
            end else begin
                wr_t w;
                w = exp_q.pop_front();
                check({w.tag, " write addr"}, mem_addr, w.a);
                check({w.tag, " write data"}, {8'h00, mem_wdata}, {8'h00, w.d});
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[idx(16'hFFFC)] = 8'h00;
        mem[idx(16'hFFFD)] = 8'hF8;
    endtask

    task automatic load(logic [15:0] base, int n, logic [8*24-1:0] code);
        for (int i = 0; i < n; i++)
            mem[idx(base + 16'(i))] = code[8*(n-1-i) +: 8];
    endtask

    task automatic run(string tag);
        int cnt;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        while (!halted && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        if (!halted) begin
            n_checks++; n_errors++;
            $display("FAIL %s watchdog: actual=running expected=halted", tag);
        end
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL %s missing writes: actual=%0d expected=0 pending", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        #(200000 * 5);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // reset state, R1
        clear_mem();
        repeat (2) @(negedge clk);
        check("R1 halted in reset", {15'd0, halted}, 16'd0);
        check("R1 we in reset", {15'd0, mem_we}, 16'd0);
        check("R1 addr in reset", mem_addr, 16'hFFFC);
        check("R1 regs zero", {dbg_a, dbg_x}, 16'h0000);
        check("R1 y/sp zero", {dbg_y, dbg_sp}, 16'h0000);
        check("R1 flags zero", {12'd0, dbg_flags}, 16'h0000);

        // Program A: subtract with borrow and compare, R9 R8
        clear_mem();
        load(16'hF800, 17, 136'hA9_50_E9_F0_E0_00_E9_60_E0_00_E9_7F_E0_00_E9_01_02);
        run("progA");
        check("R9 A after subtract chain", {8'h00, dbg_a}, 16'h007F);
        check("R9 flags NVZC after overflow", {12'd0, dbg_flags}, 16'h0005);
        check("R8 X unchanged by compare", {8'h00, dbg_x}, 16'h0000);
        check("R12 halt addr progA", halt_addr, 16'hF810);

        // Program A2: borrow out with no overflow, R9
        clear_mem();
        load(16'hF800, 5, 40'hA9_50_E9_F0_02);
        run("progA2");
        check("R9 borrow result", {8'h00, dbg_a}, 16'h005F);
        check("R9 borrow flags", {12'd0, dbg_flags}, 16'h0000);

        // Program A3: 0 - 0 - 1, R9 R4
        clear_mem();
        load(16'hF800, 5, 40'hA9_00_E9_00_02);
        run("progA3");
        check("R9 wrap to FF", {8'h00, dbg_a}, 16'h00FF);
        check("R9 negative borrow flags", {12'd0, dbg_flags}, 16'h0008);

        // Program B: inc/dec, zero page, stores, rotate, R2 R3 R4 R5 R6 R7
        clear_mem();
        load(16'hF800, 23, 184'hCA_86_10_E6_10_A4_10_88_C8_C8_A5_10_CA_8E_34_02_A9_81_E0_FE_2A_2A_02);
        expect_wr(16'h0010, 8'hFF, "R5 zp store");
        expect_wr(16'h0010, 8'h00, "R6 zp increment");
        expect_wr(16'h0234, 8'hFE, "R3 abs store");
        run("progB");
        check("R7 A after two rotates", {8'h00, dbg_a}, 16'h0007);
        check("R6 X after two decrements", {8'h00, dbg_x}, 16'h00FE);
        check("R6 Y after dec/inc", {8'h00, dbg_y}, 16'h0001);
        check("R7 flags after rotate", {12'd0, dbg_flags}, 16'h0000);
        check("R2 zp read-back in memory", {8'h00, mem[idx(16'h0010)]}, 16'h0000);
        check("R4 halt addr progB", halt_addr, 16'hF816);

        // Program C: call/return, jump, branches, R10 R11 R3
        clear_mem();
        load(16'hF800, 11, 88'hCA_9A_20_00_F9_86_20_4C_10_F8_02);
        load(16'hF900, 4, 32'hCA_CA_CA_60);
        load(16'hF810, 18, 144'hE0_FC_D0_02_B0_02_02_02_90_02_CA_E0_F8_D0_FB_86_21_02);
        expect_wr(16'h01FF, 8'hF8, "R11 push high");
        expect_wr(16'h01FE, 8'h04, "R11 push low");
        expect_wr(16'h0020, 8'hFC, "R11 return target");
        expect_wr(16'h0021, 8'hF8, "R10 loop exit");
        run("progC");
        check("R11 SP after call/return", {8'h00, dbg_sp}, 16'h00FF);
        check("R10 X after backward loop", {8'h00, dbg_x}, 16'h00F8);
        check("R10 halt addr progC", halt_addr, 16'hF821);
        check("R8 flags after final compare", {12'd0, dbg_flags}, 16'h0003);

        // Program D: taken carry-clear branch, no-op, undefined opcode, R10 R12
        clear_mem();
        load(16'hF800, 5, 40'h90_01_02_EA_FF);
        run("progD");
        check("R12 halted", {15'd0, halted}, 16'd1);
        check("R10 R12 halt addr", halt_addr, 16'hF804);
        repeat (6) @(negedge clk);
        check("R12 still halted", {15'd0, halted}, 16'd1);
        check("R12 halt addr held", halt_addr, 16'hF804);
        check("R12 regs frozen", {dbg_a, dbg_x}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule